// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a 16-bit virtual address into a physical address through one relocation pair per logical segment. The three segments are code, heap and stack. The two top bits of the virtual address pick the segment, and the remaining bits are the offset within that segment. The block checks the offset against the segment's size limit and checks the kind of access against the segment's read and write permission bits. If both checks pass, it adds the offset to the segment's base.

Each segment is set up through a configuration write port. That port only accepts writes that are marked privileged. Each segment has its own permission bits, so one segment can be shared read-only while the others stay writable.

Every request returns one cycle later with a valid strobe, the physical address, a fault flag and a 2-bit fault reason.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `rsp_valid` is 0 and every segment has base 0, limit 0 and no permissions. Any access made before configuration therefore faults with reason 2'b01.
- R2: Virtual address bits [15:14] select the segment: 2'b00 selects code, 2'b01 selects heap and 2'b10 selects stack. The offset is bits [13:0].
- R3: An access that passes both checks returns `rsp_fault`=0, `rsp_reason`=2'b00 and `rsp_paddr` = base + offset. The sum is taken modulo 2^PA_W.
- R4: An access whose offset is equal to or larger than the segment limit faults with reason 2'b01 and `rsp_paddr`=0. An offset of limit-1 is translated.
- R5: A write to a segment whose write permission is clear faults with reason 2'b10. A read from a segment whose read permission is clear also faults with reason 2'b10. In both cases `rsp_paddr`=0.
- R6: Selector 2'b11 is unmapped. Any access with that selector faults with reason 2'b11.
- R7: When several faults apply, one reason is reported: an unmapped selector first, then the limit fault, then the permission fault.
- R8: A configuration write is ignored when `cfg_priv` is 0 or when `cfg_sel` is 2'b11.
- R9: An accepted configuration write takes effect in the following cycle. A translation issued in the same cycle as the write uses the values from before the write.
- R10: `rsp_valid` equals `req_valid` delayed by one cycle. In a cycle with no request, `rsp_paddr`, `rsp_fault` and `rsp_reason` hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_priv | input | 1 | The write comes from privileged software |
| cfg_sel | input | 2 | Segment to load (00 code, 01 heap, 10 stack) |
| cfg_base | input | PA_W | New segment base |
| cfg_limit | input | VA_W-1 | New segment size; an offset must be below it |
| cfg_rd_ok | input | 1 | New read permission |
| cfg_wr_ok | input | 1 | New write permission |
| req_valid | input | 1 | Translation request |
| req_write | input | 1 | 1 for a store access, 0 for a load access |
| req_vaddr | input | VA_W | Virtual address |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_paddr | output | PA_W | Physical address (0 on a fault) |
| rsp_fault | output | 1 | The access was refused |
| rsp_reason | output | 2 | 00 none, 01 limit, 10 permission, 11 unmapped |

## Verification
A configuration write and a translation can land in the same cycle. A segment update and an access to that same segment can also land in the same cycle. The bench provokes this by driving a privileged base and limit change together with a request to that segment on one edge. It then expects a result computed from the old base and limit, and it expects the very next request to see the new ones. The bench also covers combined faults: an unmapped selector together with a write, and an out-of-range write to a read-only segment. For these it judges that the single reported reason follows the fixed priority order.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    localparam int SEL_W   = 2;
    localparam int NUM_SEG = 3;

    typedef enum logic [SEL_W-1:0] {
        SEG_CODE  = 2'b00,
        SEG_HEAP  = 2'b01,
        SEG_STACK = 2'b10,
        SEG_NONE  = 2'b11
    } seg_id_e;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'b00,
        FLT_LIMIT = 2'b01,
        FLT_PERM  = 2'b10,
        FLT_SEL   = 2'b11
    } flt_code_e;

    typedef struct packed {
        logic rd;
        logic wr;
    } perm_t;

endpackage

// File: rtl/seg_reg_file.sv
module seg_reg_file
    import seg_xlate_pkg::*;
#(
    parameter int PA_W  = 20,
    parameter int LIM_W = 15
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_we,
    input  logic                            cfg_priv,
    input  logic [SEL_W-1:0]                cfg_sel,
    input  logic [PA_W-1:0]                 cfg_base,
    input  logic [LIM_W-1:0]                cfg_limit,
    input  perm_t                           cfg_perm,
    output logic [NUM_SEG-1:0][PA_W-1:0]    seg_base_o,
    output logic [NUM_SEG-1:0][LIM_W-1:0]   seg_limit_o,
    output perm_t [NUM_SEG-1:0]             seg_perm_o
);

    typedef struct packed {
        logic [NUM_SEG-1:0][PA_W-1:0]  base;
        logic [NUM_SEG-1:0][LIM_W-1:0] limit;
        perm_t [NUM_SEG-1:0]           perm;
    } regs_t;

    regs_t              regs_d, regs_q;
    logic [NUM_SEG-1:0] hit;

    // One write-enable per segment; the unmapped selector matches none.
    for (genvar g = 0; g < NUM_SEG; g++) begin : g_hit
        assign hit[g] = cfg_we && cfg_priv && (cfg_sel == SEL_W'(g));
    end

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (hit[i]) begin
                regs_d.base[i]  = cfg_base;
                regs_d.limit[i] = cfg_limit;
                regs_d.perm[i]  = cfg_perm;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign seg_base_o  = regs_q.base;
    assign seg_limit_o = regs_q.limit;
    assign seg_perm_o  = regs_q.perm;

endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_xlate_pkg::*;
#(
    parameter int VA_W  = 16,
    parameter int PA_W  = 20,
    localparam int OFF_W = VA_W - SEL_W,
    localparam int LIM_W = OFF_W + 1
) (
    input  logic [VA_W-1:0]                 vaddr,
    input  logic                            is_write,
    input  logic [NUM_SEG-1:0][PA_W-1:0]    seg_base,
    input  logic [NUM_SEG-1:0][LIM_W-1:0]   seg_limit,
    input  perm_t [NUM_SEG-1:0]             seg_perm,
    output logic [PA_W-1:0]                 paddr,
    output logic                            fault,
    output flt_code_e                       reason
);

    logic [SEL_W-1:0] sel;
    logic [OFF_W-1:0] off;
    logic             sel_ok;
    logic [PA_W-1:0]  cur_base;
    logic [LIM_W-1:0] cur_limit;
    perm_t            cur_perm;
    logic             over_limit;
    logic             perm_bad;

    assign sel = vaddr[VA_W-1 -: SEL_W];
    assign off = vaddr[OFF_W-1:0];

    always_comb begin
        sel_ok    = 1'b0;
        cur_base  = '0;
        cur_limit = '0;
        cur_perm  = '0;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (sel == SEL_W'(i)) begin
                sel_ok    = 1'b1;
                cur_base  = seg_base[i];
                cur_limit = seg_limit[i];
                cur_perm  = seg_perm[i];
            end
        end
    end

    assign over_limit = {1'b0, off} >= cur_limit;
    assign perm_bad   = is_write ? !cur_perm.wr : !cur_perm.rd;

    // Fixed priority: unmapped selector, limit, permission.
    always_comb begin
        paddr  = '0;
        fault  = 1'b1;
        reason = FLT_NONE;
        if (!sel_ok) begin
            reason = FLT_SEL;
        end else if (over_limit) begin
            reason = FLT_LIMIT;
        end else if (perm_bad) begin
            reason = FLT_PERM;
        end else begin
            fault = 1'b0;
            paddr = cur_base + PA_W'(off);
        end
    end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int VA_W  = 16,
    parameter int PA_W  = 20,
    localparam int LIM_W = VA_W - SEL_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_priv,
    input  logic [1:0]       cfg_sel,
    input  logic [PA_W-1:0]  cfg_base,
    input  logic [LIM_W-1:0] cfg_limit,
    input  logic             cfg_rd_ok,
    input  logic             cfg_wr_ok,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_fault,
    output logic [1:0]       rsp_reason
);

    typedef struct packed {
        logic            valid;
        logic [PA_W-1:0] paddr;
        logic            fault;
        flt_code_e       reason;
    } rsp_t;

    logic [NUM_SEG-1:0][PA_W-1:0]  seg_base;
    logic [NUM_SEG-1:0][LIM_W-1:0] seg_limit;
    perm_t [NUM_SEG-1:0]           seg_perm;
    perm_t                         cfg_perm;
    logic [PA_W-1:0]               xl_paddr;
    logic                          xl_fault;
    flt_code_e                     xl_reason;
    rsp_t                          rsp_d, rsp_q;

    assign cfg_perm = '{rd: cfg_rd_ok, wr: cfg_wr_ok};

    seg_reg_file #(.PA_W(PA_W), .LIM_W(LIM_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_priv    (cfg_priv),
        .cfg_sel     (cfg_sel),
        .cfg_base    (cfg_base),
        .cfg_limit   (cfg_limit),
        .cfg_perm    (cfg_perm),
        .seg_base_o  (seg_base),
        .seg_limit_o (seg_limit),
        .seg_perm_o  (seg_perm)
    );

    seg_check #(.VA_W(VA_W), .PA_W(PA_W)) u_check (
        .vaddr     (req_vaddr),
        .is_write  (req_write),
        .seg_base  (seg_base),
        .seg_limit (seg_limit),
        .seg_perm  (seg_perm),
        .paddr     (xl_paddr),
        .fault     (xl_fault),
        .reason    (xl_reason)
    );

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            rsp_d.paddr  = xl_paddr;
            rsp_d.fault  = xl_fault;
            rsp_d.reason = xl_reason;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid  = rsp_q.valid;
    assign rsp_paddr  = rsp_q.paddr;
    assign rsp_fault  = rsp_q.fault;
    assign rsp_reason = rsp_q.reason;

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
    parameter int VA_W = 16,
    parameter int PA_W = 20
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [VA_W-1:0] req_vaddr,
    input logic            rsp_valid,
    input logic [PA_W-1:0] rsp_paddr,
    input logic            rsp_fault,
    input logic [1:0]      rsp_reason
);

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R10

    AST_IDLE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(rsp_paddr) && $stable(rsp_reason) && $stable(rsp_fault)); // R10

    AST_UNMAPPED_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_vaddr[VA_W-1 -: 2] == 2'b11) |=> (rsp_fault && rsp_reason == 2'b11)); // R6

    AST_FAULT_MATCHES_REASON: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault == (rsp_reason != 2'b00))); // R5

    AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0)); // R4

endmodule

bind seg_xlate seg_xlate_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_vaddr  (req_vaddr),
    .rsp_valid  (rsp_valid),
    .rsp_paddr  (rsp_paddr),
    .rsp_fault  (rsp_fault),
    .rsp_reason (rsp_reason)
);

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;

    localparam int VA_W  = 16;
    localparam int PA_W  = 20;
    localparam int LIM_W = 15;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic             cfg_priv = 1'b0;
    logic [1:0]       cfg_sel = '0;
    logic [PA_W-1:0]  cfg_base = '0;
    logic [LIM_W-1:0] cfg_limit = '0;
    logic             cfg_rd_ok = 1'b0;
    logic             cfg_wr_ok = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_write = 1'b0;
    logic [VA_W-1:0]  req_vaddr = '0;
    logic             rsp_valid;
    logic [PA_W-1:0]  rsp_paddr;
    logic             rsp_fault;
    logic [1:0]       rsp_reason;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #10 clk = ~clk;

    seg_xlate #(.VA_W(VA_W), .PA_W(PA_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_priv(cfg_priv), .cfg_sel(cfg_sel),
        .cfg_base(cfg_base), .cfg_limit(cfg_limit),
        .cfg_rd_ok(cfg_rd_ok), .cfg_wr_ok(cfg_wr_ok),
        .req_valid(req_valid), .req_write(req_write), .req_vaddr(req_vaddr),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault), .rsp_reason(rsp_reason)
    );

    task automatic check_rsp(input string tag, input logic ef, input logic [1:0] er,
                             input logic [PA_W-1:0] ep);
        n_chk++;
        if (rsp_valid !== 1'b1 || rsp_fault !== ef || rsp_reason !== er || rsp_paddr !== ep) begin
            n_bad++;
            $display("FAIL %s: got v=%b f=%b r=%b pa=%h, expected v=1 f=%b r=%b pa=%h",
                     tag, rsp_valid, rsp_fault, rsp_reason, rsp_paddr, ef, er, ep);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [PA_W-1:0] base,
                             input logic [LIM_W-1:0] lim, input logic rd, input logic wr,
                             input logic priv);
        @(negedge clk);
        cfg_we = 1'b1; cfg_priv = priv; cfg_sel = sel;
        cfg_base = base; cfg_limit = lim; cfg_rd_ok = rd; cfg_wr_ok = wr;
        @(negedge clk);
        cfg_we = 1'b0; cfg_priv = 1'b0;
    endtask

    task automatic xlate(input string tag, input logic [VA_W-1:0] va, input logic wr,
                         input logic ef, input logic [1:0] er, input logic [PA_W-1:0] ep);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        check_rsp(tag, ef, er, ep);
    endtask

    task automatic t_reset;
        n_chk++;
        if (rsp_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: rsp_valid got %b expected 0", rsp_valid);
        end
        xlate("R1 code before setup", 16'h0000, 1'b0, 1'b1, 2'b01, '0);
        xlate("R1 stack before setup", 16'h8004, 1'b1, 1'b1, 2'b01, '0);
    endtask

    task automatic t_setup_and_map;
        cfg_write(2'b00, 20'h10000, 15'h1000, 1'b1, 1'b0, 1'b1);
        cfg_write(2'b01, 20'h20000, 15'h4000, 1'b1, 1'b1, 1'b1);
        cfg_write(2'b10, 20'h30000, 15'h0800, 1'b1, 1'b1, 1'b1);
        xlate("R2 R3 code read", 16'h0123, 1'b0, 1'b0, 2'b00, 20'h10123);
        xlate("R2 R3 heap write", 16'h4123, 1'b1, 1'b0, 2'b00, 20'h20123);
        xlate("R2 R3 stack read", 16'h8010, 1'b0, 1'b0, 2'b00, 20'h30010);
    endtask

    task automatic t_limit;
        xlate("R4 code last offset", 16'h0FFF, 1'b0, 1'b0, 2'b00, 20'h10FFF);
        xlate("R4 code at limit", 16'h1000, 1'b0, 1'b1, 2'b01, '0);
        xlate("R4 heap last offset", 16'h7FFF, 1'b0, 1'b0, 2'b00, 20'h23FFF);
        xlate("R4 stack beyond", 16'h8900, 1'b1, 1'b1, 2'b01, '0);
    endtask

    task automatic t_perm;
        xlate("R5 write to read-only code", 16'h0010, 1'b1, 1'b1, 2'b10, '0);
        cfg_write(2'b10, 20'h30000, 15'h0800, 1'b0, 1'b1, 1'b1);
        xlate("R5 read from write-only stack", 16'h8020, 1'b0, 1'b1, 2'b10, '0);
        xlate("R5 write to write-only stack", 16'h8020, 1'b1, 1'b0, 2'b00, 20'h30020);
    endtask

    task automatic t_unmapped;
        xlate("R6 unmapped read", 16'hC000, 1'b0, 1'b1, 2'b11, '0);
        xlate("R6 R7 unmapped write", 16'hFFFF, 1'b1, 1'b1, 2'b11, '0);
        xlate("R7 limit before perm", 16'h1800, 1'b1, 1'b1, 2'b01, '0);
    endtask

    task automatic t_priv;
        cfg_write(2'b00, 20'h50000, 15'h7FFF, 1'b1, 1'b1, 1'b0);
        xlate("R8 unprivileged write ignored", 16'h0123, 1'b0, 1'b0, 2'b00, 20'h10123);
        xlate("R8 unprivileged perm ignored", 16'h0123, 1'b1, 1'b1, 2'b10, '0);
        cfg_write(2'b11, 20'h60000, 15'h7FFF, 1'b1, 1'b1, 1'b1);
        xlate("R8 selector 3 write, code", 16'h0040, 1'b0, 1'b0, 2'b00, 20'h10040);
        xlate("R8 selector 3 write, heap", 16'h4040, 1'b0, 1'b0, 2'b00, 20'h20040);
        xlate("R8 selector 3 write, unmapped", 16'hC040, 1'b0, 1'b1, 2'b11, '0);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        cfg_we = 1'b1; cfg_priv = 1'b1; cfg_sel = 2'b01;
        cfg_base = 20'h40000; cfg_limit = 15'h0100; cfg_rd_ok = 1'b1; cfg_wr_ok = 1'b1;
        req_valid = 1'b1; req_write = 1'b0; req_vaddr = 16'h4200;
        @(negedge clk);
        cfg_we = 1'b0; cfg_priv = 1'b0; req_valid = 1'b0;
        check_rsp("R9 same cycle uses old values", 1'b0, 2'b00, 20'h20200);
        xlate("R9 next cycle uses new limit", 16'h4200, 1'b0, 1'b1, 2'b01, '0);
        xlate("R9 next cycle uses new base", 16'h4020, 1'b0, 1'b0, 2'b00, 20'h40020);
    endtask

    task automatic t_wrap_and_latency;
        cfg_write(2'b00, 20'hFFFF0, 15'h0100, 1'b1, 1'b0, 1'b1);
        xlate("R3 sum wraps", 16'h0020, 1'b0, 1'b0, 2'b00, 20'h00010);
        @(negedge clk);
        n_chk++;
        if (rsp_valid !== 1'b0 || rsp_paddr !== 20'h00010 || rsp_reason !== 2'b00) begin
            n_bad++;
            $display("FAIL R10: idle got v=%b pa=%h r=%b expected v=0 pa=00010 r=00",
                     rsp_valid, rsp_paddr, rsp_reason);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_setup_and_map();
        t_limit();
        t_perm();
        t_unmapped();
        t_priv();
        t_same_cycle();
        t_wrap_and_latency();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule